// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block lets a CPU drive three 8-bit parallel ports, called A, B and C, through a small register interface. The interface has an 8-bit data bus, a 2-bit address, a chip select, and single-cycle read and write strobes. Each port pin has its own input value, output value and output enable, so pads or a board-level buffer can be attached outside the block. The CPU-side interface is synchronous to `clk_i`. Reads return data combinationally in the same cycle as the strobe. Every side effect of a read or write takes place at the next rising clock edge.

Ports A and B form two groups. Each group can run in one of two modes:
- Basic mode: plain latched outputs, or live unlatched inputs.
- Strobed mode: the data is latched, and a handshake runs on two lines of port C.

Port C splits into an upper half and a lower half. In basic mode each half has its own direction setting. When a group is in strobed mode, its half of port C supplies that group's handshake lines.

A single control address accepts two kinds of word, and bit 7 selects between them:
- A configuration word sets the modes and directions, and it clears every output latch.
- A single-bit word sets or clears one bit of the port C output latch.

Top module: `ppi_top`

## Requirements
- R1: After reset all three ports are inputs in basic mode. All output enables are 0 and every output latch is 0.
- R2: When `cs_i` and `rd_i` are both high, address 00 reads port A, 01 reads port B, 10 reads port C and 11 reads 0x00. At all other times `rdata_o` is 0x00.
- R3: A write to address 11 with bit 7 = 1 is a configuration word. Bit 0 is the lower port C half direction, bit 1 is the port B direction, bit 2 is the group B mode (1 = strobed), bit 3 is the upper port C half direction, bit 4 is the port A direction, and bits 6:5 are the group A mode (01 = strobed; 00, 10 and 11 = basic). A direction bit of 1 means input, and an input has its output enables at 0.
- R4: A configuration word clears the A, B and C output latches to 0, clears both input-full flags and sets both output-full-n flags high.
- R5: In basic output mode, a write to a port drives the written byte on its pins from the next cycle. A read of that port returns the written byte, whatever is on its input pins.
- R6: In basic input mode, a port read returns the input pins as they are in that cycle, with no latching.
- R7: A write to port C loads all 8 latch bits. A port C read returns the driven value for bits whose output enable is 1 and the input pin for the other bits.
- R8: A write to address 11 with bit 7 = 0 loads port C latch bit [3:1] with bit 0. The other latch bits and the configuration do not change.
- R9: In strobed input mode, a high-to-low change sampled on the strobe pin latches the data pins and raises the input-full flag from the next cycle. Port reads then return the latched byte. Group A uses strobe `pc_i[4]` and flag `pc_o[5]`. Group B uses strobe `pc_i[0]` and flag `pc_o[1]`.
- R10: A read of a strobed input port clears its input-full flag after that edge. A strobe edge in the same cycle as the read wins, and the flag stays high.
- R11: In strobed output mode, a port write drives the output-full-n flag low (`pc_o[5]` for A, `pc_o[1]` for B). A sampled high-to-low change on the acknowledge pin (`pc_i[4]` for A, `pc_i[0]` for B) returns it high.
- R12: While a group is strobed, its port C half has output enable 0 on the strobe bit and 1 on the flag bit. The two upper bits of that half follow the half's direction setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while cs_i and rd_i are high |
| pa_i | input | 8 | Port A input pins |
| pa_o | output | 8 | Port A output values |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B input pins |
| pb_o | output | 8 | Port B output values |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C input pins, including handshake inputs |
| pc_o | output | 8 | Port C output values, including handshake flags |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
A corrupted configuration register shows up on the output enable vectors in the cycle after the control write. A wrong latch bit, or a set/reset word aimed at the wrong bit, shows on `pc_o` one edge after the write. A stuck or mistimed handshake flag shows on its port C line one edge after the strobe, acknowledge, read or write that should have moved it. A missing data latch shows as a read that follows the pins after they change. The bench therefore checks every flag line and enable vector in the cycle right after each event. It also moves the input pins between the strobe and the read.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned PW  = 8;
  localparam int unsigned AW  = 2;
  localparam int unsigned HW  = PW / 2;
  localparam int unsigned IXW = $clog2(PW);

  typedef enum logic [AW-1:0] {
    ADR_PA  = 2'd0,
    ADR_PB  = 2'd1,
    ADR_PC  = 2'd2,
    ADR_CTL = 2'd3
  } ppi_addr_e;

  typedef struct packed {
    logic a_stb;
    logic a_in;
    logic ch_in;
    logic b_stb;
    logic b_in;
    logic cl_in;
  } ppi_cfg_t;

  localparam ppi_cfg_t CFG_RST = '{a_stb: 1'b0, a_in: 1'b1, ch_in: 1'b1,
                                   b_stb: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_cfg.sv
module ppi_cfg
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic [PW-1:0] wdata_i,
  output ppi_cfg_t      cfg_o,
  output logic          mode_set_o,
  output logic          bsr_o
);
  ppi_cfg_t cfg_q;

  assign mode_set_o = ctl_wr_i & wdata_i[PW-1];
  assign bsr_o      = ctl_wr_i & ~wdata_i[PW-1];
  assign cfg_o      = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (mode_set_o) begin
      cfg_q <= '{a_stb: (wdata_i[6:5] == 2'b01), a_in: wdata_i[4], ch_in: wdata_i[3],
                 b_stb: wdata_i[2], b_in: wdata_i[1], cl_in: wdata_i[0]};
    end
  end

  assert_bsr_keeps_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_o |=> $stable(cfg_q));
endmodule

// File: rtl/ppi_port.sv
module ppi_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_mode_i,
  input  logic         dir_in_i,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  input  logic         hs_ni,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] rdata_o,
  output logic         flag_o
);
  logic [W-1:0] out_q, in_q;
  logic         ibf_q, obf_nq, hs_q;
  logic         strb_in, strb_out, hs_fall;

  assign strb_in  = stb_mode_i & dir_in_i;
  assign strb_out = stb_mode_i & ~dir_in_i;
  assign hs_fall  = hs_q & ~hs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      in_q   <= '0;
      ibf_q  <= 1'b0;
      obf_nq <= 1'b1;
      hs_q   <= 1'b1;
    end else begin
      hs_q <= hs_ni;
      if (clr_i) begin
        out_q  <= '0;
        ibf_q  <= 1'b0;
        obf_nq <= 1'b1;
      end else begin
        if (wr_i) out_q <= wdata_i;
        if (strb_in) begin
          if (hs_fall) begin
            in_q  <= pin_i;
            ibf_q <= 1'b1;
          end else if (rd_i) begin
            ibf_q <= 1'b0;
          end
        end
        if (strb_out) begin
          if (wr_i)         obf_nq <= 1'b0;
          else if (hs_fall) obf_nq <= 1'b1;
        end
      end
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = {W{~dir_in_i}};
  assign rdata_o  = dir_in_i ? (stb_mode_i ? in_q : pin_i) : out_q;
  assign flag_o   = strb_in ? ibf_q : obf_nq;

  assert_ibf_on_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_in && hs_fall && !clr_i) |=> ibf_q);
  assert_read_clears_ibf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_in && rd_i && !hs_fall && !clr_i) |=> !ibf_q);
  assert_obf_low_on_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_out && wr_i && !clr_i) |=> !obf_nq);
  assert_mode_set_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (out_q == '0 && !ibf_q && obf_nq));
endmodule

// File: rtl/ppi_pc.sv
module ppi_pc
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ppi_cfg_t      cfg_i,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          bsr_i,
  input  logic [PW-1:0] wdata_i,
  input  logic          flag_a_i,
  input  logic          flag_b_i,
  input  logic [PW-1:0] pin_i,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe_o,
  output logic [PW-1:0] rdata_o
);
  logic [PW-1:0]        lat_q;
  logic [1:0][HW-1:0]   half_o, half_oe;
  logic [IXW-1:0]       bit_idx;

  assign bit_idx = wdata_i[IXW:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (clr_i)  lat_q <= '0;
    else if (wr_i)   lat_q <= wdata_i;
    else if (bsr_i)  lat_q[bit_idx] <= wdata_i[0];
  end

  // half 1 serves group A, half 0 serves group B
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic          stb, hin, flag;
    logic [HW-1:0] lat;
    assign stb  = (h == 1) ? cfg_i.a_stb : cfg_i.b_stb;
    assign hin  = (h == 1) ? cfg_i.ch_in : cfg_i.cl_in;
    assign flag = (h == 1) ? flag_a_i    : flag_b_i;
    assign lat  = lat_q[HW*h +: HW];
    assign half_o[h]  = stb ? {lat[HW-1:2], flag, lat[0]} : lat;
    assign half_oe[h] = stb ? {{(HW-2){~hin}}, 1'b1, 1'b0} : {HW{~hin}};
  end

  assign pin_o    = half_o;
  assign pin_oe_o = half_oe;
  assign rdata_o  = (pin_o & pin_oe_o) | (pin_i & ~pin_oe_o);

  assert_bsr_target_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_i |=> lat_q[$past(bit_idx)] == $past(wdata_i[0]));
  assert_bsr_other_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_i |=> ((lat_q ^ $past(lat_q)) & ~(8'b1 << $past(bit_idx))) == 8'h00);
  assert_hs_enables_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.a_stb |-> (!pin_oe_o[HW] && pin_oe_o[HW+1]));
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] rdata_o,
  input  logic [PW-1:0] pa_i,
  output logic [PW-1:0] pa_o,
  output logic [PW-1:0] pa_oe_o,
  input  logic [PW-1:0] pb_i,
  output logic [PW-1:0] pb_o,
  output logic [PW-1:0] pb_oe_o,
  input  logic [PW-1:0] pc_i,
  output logic [PW-1:0] pc_o,
  output logic [PW-1:0] pc_oe_o
);
  ppi_cfg_t cfg;
  logic     mode_set, bsr, ctl_wr, pc_wr;
  logic [1:0]         g_wr, g_rd, g_stb, g_in, g_hs_n, g_flag;
  logic [1:0][PW-1:0] g_pin_i, g_pin_o, g_oe, g_rdata;
  logic [PW-1:0]      pc_rdata;

  assign ctl_wr = cs_i & wr_i & (addr_i == ADR_CTL);
  assign pc_wr  = cs_i & wr_i & (addr_i == ADR_PC);
  assign g_wr   = {cs_i & wr_i & (addr_i == ADR_PB), cs_i & wr_i & (addr_i == ADR_PA)};
  assign g_rd   = {cs_i & rd_i & (addr_i == ADR_PB), cs_i & rd_i & (addr_i == ADR_PA)};
  assign g_stb  = {cfg.b_stb, cfg.a_stb};
  assign g_in   = {cfg.b_in, cfg.a_in};
  assign g_hs_n = {pc_i[0], pc_i[HW]};
  assign g_pin_i = {pb_i, pa_i};

  ppi_cfg u_cfg (
    .clk_i, .rst_ni, .ctl_wr_i(ctl_wr), .wdata_i,
    .cfg_o(cfg), .mode_set_o(mode_set), .bsr_o(bsr)
  );

  for (genvar g = 0; g < 2; g++) begin : g_grp
    ppi_port #(.W(PW)) u_port (
      .clk_i, .rst_ni,
      .stb_mode_i(g_stb[g]), .dir_in_i(g_in[g]), .clr_i(mode_set),
      .wr_i(g_wr[g]), .rd_i(g_rd[g]), .wdata_i,
      .pin_i(g_pin_i[g]), .hs_ni(g_hs_n[g]),
      .pin_o(g_pin_o[g]), .pin_oe_o(g_oe[g]), .rdata_o(g_rdata[g]), .flag_o(g_flag[g])
    );
  end

  ppi_pc u_pc (
    .clk_i, .rst_ni, .cfg_i(cfg), .clr_i(mode_set), .wr_i(pc_wr), .bsr_i(bsr),
    .wdata_i, .flag_a_i(g_flag[0]), .flag_b_i(g_flag[1]), .pin_i(pc_i),
    .pin_o(pc_o), .pin_oe_o(pc_oe_o), .rdata_o(pc_rdata)
  );

  assign pa_o    = g_pin_o[0];
  assign pa_oe_o = g_oe[0];
  assign pb_o    = g_pin_o[1];
  assign pb_oe_o = g_oe[1];

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      case (addr_i)
        ADR_PA:  rdata_o = g_rdata[0];
        ADR_PB:  rdata_o = g_rdata[1];
        ADR_PC:  rdata_o = pc_rdata;
        default: rdata_o = '0;
      endcase
    end
  end

  assert_ctl_read_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == ADR_CTL) |-> rdata_o == 8'h00);
endmodule

// File: tb/ppi_top_tb.sv
module ppi_top_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs = 0, wr = 0, rd = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = 8'h11;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

  always #5 clk = ~clk;

  ppi_top u_dut (
    .clk_i(clk), .rst_ni, .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .pa_i, .pa_o, .pa_oe_o(pa_oe), .pb_i, .pb_o, .pb_oe_o(pb_oe),
    .pc_i, .pc_o, .pc_oe_o(pc_oe)
  );

  typedef struct {
    int         sel;
    logic [7:0] mask;
    logic [7:0] exp;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  localparam int S_RD = 0, S_PA = 1, S_PAOE = 2, S_PB = 3, S_PBOE = 4, S_PC = 5, S_PCOE = 6;

  function automatic logic [7:0] pick(int sel);
    case (sel)
      S_RD:    return rdata;
      S_PA:    return pa_o;
      S_PAOE:  return pa_oe;
      S_PB:    return pb_o;
      S_PBOE:  return pb_oe;
      S_PC:    return pc_o;
      default: return pc_oe;
    endcase
  endfunction

  // monitor: compares queued expectations 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = q.pop_front();
        act = pick(e.sel) & e.mask;
        checks++;
        if (act !== (e.exp & e.mask)) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, act, e.exp & e.mask);
        end
      end
    end
  end

  task automatic chk(int sel, logic [7:0] mask, logic [7:0] exp, string req);
    exp_t e;
    e.sel = sel; e.mask = mask; e.exp = exp; e.req = req;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
    cs = 0; wr = 0; rd = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; rd = 0; addr = a; wdata = d;
    @(posedge clk);
    #1;
    cs = 0; wr = 0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    cs = 1; rd = 1; wr = 0; addr = a;
    chk(S_RD, 8'hFF, exp, req);
    @(posedge clk);
    #1;
    cs = 0; rd = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk(S_PAOE, 8'hFF, 8'h00, "R1"); chk(S_PBOE, 8'hFF, 8'h00, "R1");
    chk(S_PCOE, 8'hFF, 8'h00, "R1"); chk(S_PA, 8'hFF, 8'h00, "R1");
    chk(S_PB, 8'hFF, 8'h00, "R1");   chk(S_PC, 8'hFF, 8'h00, "R1");
    step();

    // R6 / R2 basic input reads and address map
    pa_i = 8'h5A; rd_chk(2'd0, 8'h5A, "R6");
    pa_i = 8'h3C; rd_chk(2'd0, 8'h3C, "R6");
    pb_i = 8'hC3; rd_chk(2'd1, 8'hC3, "R2");
    rd_chk(2'd2, 8'h11, "R7");
    rd_chk(2'd3, 8'h00, "R2");
    chk(S_RD, 8'hFF, 8'h00, "R2"); step();

    // R3 configuration: A out, B out, upper C out, lower C in
    wr_reg(2'd3, 8'h81);
    chk(S_PAOE, 8'hFF, 8'hFF, "R3"); chk(S_PBOE, 8'hFF, 8'hFF, "R3");
    chk(S_PCOE, 8'hFF, 8'hF0, "R3"); step();

    // R5 basic output
    wr_reg(2'd0, 8'hA5);
    chk(S_PA, 8'hFF, 8'hA5, "R5"); step();
    pa_i = 8'h3C; rd_chk(2'd0, 8'hA5, "R5");
    wr_reg(2'd1, 8'h11);
    wr_reg(2'd2, 8'hFF);
    chk(S_PB, 8'hFF, 8'h11, "R5"); chk(S_PC, 8'hFF, 8'hFF, "R7"); step();
    rd_chk(2'd2, 8'hF1, "R7");

    // R8 bit set/reset
    wr_reg(2'd3, 8'h0C);
    chk(S_PC, 8'hFF, 8'hBF, "R8"); chk(S_PAOE, 8'hFF, 8'hFF, "R8");
    chk(S_PB, 8'hFF, 8'h11, "R8"); step();
    rd_chk(2'd2, 8'hB1, "R8");
    wr_reg(2'd3, 8'h00);
    chk(S_PC, 8'hFF, 8'hBE, "R8"); chk(S_PCOE, 8'hFF, 8'hF0, "R8"); step();
    wr_reg(2'd3, 8'h01);
    chk(S_PC, 8'hFF, 8'hBF, "R8"); step();

    // R4 configuration clears latches
    wr_reg(2'd3, 8'h80);
    chk(S_PA, 8'hFF, 8'h00, "R4"); chk(S_PB, 8'hFF, 8'h00, "R4");
    chk(S_PC, 8'hFF, 8'h00, "R4"); chk(S_PCOE, 8'hFF, 8'hFF, "R3"); step();
    wr_reg(2'd2, 8'h0F);
    wr_reg(2'd3, 8'hC0);   // group A mode 10 acts as basic
    chk(S_PCOE, 8'hFF, 8'hFF, "R3"); chk(S_PC, 8'hFF, 8'h00, "R4"); step();

    // R9 / R10 / R12 strobed input on group A
    wr_reg(2'd3, 8'hB0);
    chk(S_PAOE, 8'hFF, 8'h00, "R3"); chk(S_PCOE, 8'hFF, 8'hEF, "R12");
    chk(S_PC, 8'h20, 8'h00, "R4"); step();
    pa_i = 8'h77; pc_i = 8'h01; tick();
    chk(S_PC, 8'h20, 8'h20, "R9"); step();
    pa_i = 8'h00; rd_chk(2'd0, 8'h77, "R9");
    chk(S_PC, 8'h20, 8'h00, "R10"); step();
    pc_i = 8'h11; tick();
    pa_i = 8'h12; pc_i = 8'h01; tick();
    chk(S_PC, 8'h20, 8'h20, "R9"); step();
    rd_chk(2'd0, 8'h12, "R9");
    pc_i = 8'h11; tick();
    pa_i = 8'h55; pc_i = 8'h01;     // strobe edge lands with the read
    rd_chk(2'd0, 8'h12, "R10");
    chk(S_PC, 8'h20, 8'h20, "R10"); step();
    rd_chk(2'd0, 8'h55, "R9");

    // R11 / R12 strobed output on group B
    pc_i = 8'h11;
    wr_reg(2'd3, 8'h9D);
    chk(S_PCOE, 8'hFF, 8'h02, "R12"); chk(S_PC, 8'h02, 8'h02, "R11");
    chk(S_PBOE, 8'hFF, 8'hFF, "R3");  chk(S_PA, 8'hFF, 8'h00, "R4"); step();
    wr_reg(2'd1, 8'h3E);
    chk(S_PB, 8'hFF, 8'h3E, "R11"); chk(S_PC, 8'h02, 8'h00, "R11"); step();
    pc_i = 8'h10; tick();
    chk(S_PC, 8'h02, 8'h02, "R11"); step();
    pc_i = 8'h11;

    // R9 / R10 strobed input on group B
    wr_reg(2'd3, 8'h9F);
    chk(S_PCOE, 8'hFF, 8'h02, "R12"); step();
    pb_i = 8'h6D; pc_i = 8'h10; tick();
    chk(S_PC, 8'h02, 8'h02, "R9"); step();
    pb_i = 8'h00; rd_chk(2'd1, 8'h6D, "R9");
    chk(S_PC, 8'h02, 8'h00, "R10"); step();

    step(); step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule